// File: doc/BRIEF.md
# Prioritized vectored interrupt front end

This block sits next to a small CPU core and collects five interrupt requests. They are a non-maskable input, a maskable input that latches on a rising edge, two maskable inputs that respond to level, and a low-priority external input that has no vector. Each input passes through a synchronizer and is conditioned according to its trigger style. The block applies a global enable and per-input masks, and picks one winner by fixed priority. The core signals instruction boundaries with a strobe, and the block samples only at those strobes. When a winner is accepted, the block raises a request and presents either a 16-bit vector address or a non-vectored flag. These outputs hold until the core acknowledges.

The core controls the block with three kinds of input: one-cycle pulses that set or clear the global enable, an acknowledge pulse, and a mask-write strobe that carries an 8-bit control word. A status byte gives software a readback of the serial input bit, the pending maskable sources, the enable flag and the masks. The control word also loads a serial output bit, which the block holds in a register.

Top module: `irq_front`

## Requirements
- R1: When several candidates are eligible at the same boundary, the winner follows the fixed order nmi, then edge, then level-high, then level-low, then external.
- R2: The vector outputs are 0x0024 for nmi, 0x003C for edge, 0x0034 for level-high and 0x002C for level-low. For an external win, irq_nonvec is 1 and irq_vec is 0x0000.
- R3: The nmi input ignores the enable and the masks. A rising edge arms a latch, and a request is taken only if the latch is armed and the pin is still high at the boundary. Acknowledging an nmi disarms the latch, and it cannot fire again until the pin has gone low and then risen.
- R4: The edge input is latched on its rising edge and stays pending after the pin falls. The latch is cleared by reset, by acknowledging an edge win, or by a mask write with bit 4 = 1. Bit 4 acts whatever the value of bit 3.
- R5: The level-high and level-low inputs, and the external input, count only if the pin is high at the sampling boundary.
- R6: The global enable gates all four maskable inputs. ien_set sets it. ien_clr, reset, and any accepted acknowledge clear it, and a clear wins over a set in the same cycle.
- R7: A mask write changes the masks only when bit 3 is 1. Bit 2 masks the edge input, bit 1 masks level-high and bit 0 masks level-low, and a 1 blocks that input. The external input has no mask. Reset sets all three masks.
- R8: In a mask write, bit 6 = 1 loads bit 7 into ser_out. Bit 5 has no effect.
- R9: A request is taken only on a cycle with insn_end high. The request and its vector then hold until ack, and no new sample is taken while a request is outstanding. An ack with no outstanding request is ignored.
- R10: stat_word is {serial in, edge pending, level-high pin, level-low pin, enable, mask edge, mask level-high, mask level-low}, from bit 7 down to bit 0. Its reset value is 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_in | input | 1 | Non-maskable request pin |
| edg_in | input | 1 | Edge-latched maskable request pin |
| lvh_in | input | 1 | Level-sensitive maskable pin, higher priority |
| lvl_in | input | 1 | Level-sensitive maskable pin, lower priority |
| ext_in | input | 1 | Non-vectored level request pin |
| ser_in | input | 1 | Serial input bit reported in status |
| insn_end | input | 1 | Instruction boundary strobe |
| ien_set | input | 1 | Pulse that sets the global enable |
| ien_clr | input | 1 | Pulse that clears the global enable |
| ack | input | 1 | Acknowledge pulse for the outstanding request |
| mask_wr | input | 1 | Mask/control word write strobe |
| mask_wdata | input | 8 | Mask/control word |
| irq_req | output | 1 | Request outstanding |
| irq_vec | output | 16 | Vector address of the accepted source |
| irq_nonvec | output | 1 | Accepted source is the external input |
| stat_word | output | 8 | Status readback byte |
| ser_out | output | 1 | Held serial output bit |

## Verification
The pins pass through two synchronizer flops, and the edge latches add one more flop. A pin change therefore shows up in stat_word after two clock edges, and an nmi or edge latch is armed after three. The bench waits five cycles after each pin change before it strobes. irq_req and the vector appear at the clock edge that samples insn_end. They drop at the edge that samples ack, and that same edge clears the enable. Mask writes reach stat_word and ser_out at the edge that samples mask_wr. Every check is made on the falling edge that follows the edge at which the result is due.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

    // number of request sources, index 0 is highest priority
    localparam int NSRC     = 5;
    localparam int VEC_W    = 16;
    localparam int MSK_W    = 3;
    localparam int SYNC_W   = NSRC + 1;

    // source indices
    localparam int IX_NMI   = 0;
    localparam int IX_EDGE  = 1;
    localparam int IX_LVH   = 2;
    localparam int IX_LVL   = 3;
    localparam int IX_EXT   = NSRC - 1;
    localparam int IX_SER   = NSRC;

    // vector per source, element 0 is the nmi vector
    localparam logic [NSRC-1:0][VEC_W-1:0] VEC_TAB = {
        16'h0000, 16'h002C, 16'h0034, 16'h003C, 16'h0024
    };

    // control word bit positions
    localparam int CW_MSK_EN  = 3;
    localparam int CW_EDGE_CL = 4;
    localparam int CW_IGN     = 5;
    localparam int CW_SER_EN  = 6;
    localparam int CW_SER_VAL = 7;

    typedef struct packed {
        logic nmi_prev;
        logic edge_prev;
        logic nmi_lat;
        logic edge_lat;
    } cond_st_t;

    typedef struct packed {
        logic            req;
        logic [NSRC-1:0] sel;
        logic            ien;
        logic [MSK_W-1:0] msk;
        logic            ser_out;
    } core_st_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            logic clk_unused;
            logic rst_unused;
            assign clk_unused = clk;
            assign rst_unused = rst_n;
            assign q_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_d;
            logic [STAGES-1:0][W-1:0] chain_q;

            always_comb begin
                chain_d[0] = d_in;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= chain_d;
                end
            end

            assign q_out = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_front_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    input  logic edge_s,
    input  logic nmi_clr,
    input  logic edge_clr,
    output logic nmi_live,
    output logic edge_pend
);

    cond_st_t st_d;
    cond_st_t st_q;
    logic     nmi_rise;
    logic     edge_rise;

    always_comb begin
        st_d           = st_q;
        nmi_rise       = nmi_s & ~st_q.nmi_prev;
        edge_rise      = edge_s & ~st_q.edge_prev;
        st_d.nmi_prev  = nmi_s;
        st_d.edge_prev = edge_s;
        // a fresh edge wins over a clear in the same cycle
        st_d.nmi_lat   = nmi_rise  | (st_q.nmi_lat  & ~nmi_clr);
        st_d.edge_lat  = edge_rise | (st_q.edge_lat & ~edge_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // nmi needs the armed latch and a still-high pin
    assign nmi_live  = st_q.nmi_lat & nmi_s;
    assign edge_pend = st_q.edge_lat;

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_front_pkg::*;
(
    input  logic [NSRC-1:0]  cand,
    input  logic [NSRC-1:0]  sel,
    output logic [NSRC-1:0]  grant,
    output logic [VEC_W-1:0] vec,
    output logic             nonvec
);

    logic [NSRC:0] above;

    assign above[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_prio
            assign grant[i]   = cand[i] & ~above[i];
            assign above[i+1] = above[i] | cand[i];
        end
    endgenerate

    always_comb begin
        vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel[i]) begin
                vec = vec | VEC_TAB[i];
            end
        end
    end

    assign nonvec = sel[IX_EXT];

endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_in,
    input  logic             edg_in,
    input  logic             lvh_in,
    input  logic             lvl_in,
    input  logic             ext_in,
    input  logic             ser_in,
    input  logic             insn_end,
    input  logic             ien_set,
    input  logic             ien_clr,
    input  logic             ack,
    input  logic             mask_wr,
    input  logic [7:0]       mask_wdata,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_nonvec,
    output logic [7:0]       stat_word,
    output logic             ser_out
);

    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;
    logic              nmi_live;
    logic              edge_pend;
    logic              nmi_clr;
    logic              edge_clr;
    logic              ack_ok;
    logic [NSRC-1:0]   cand;
    logic [NSRC-1:0]   grant;
    logic              wr_unused;
    core_st_t          st_d;
    core_st_t          st_q;

    assign wr_unused = mask_wdata[CW_IGN];

    assign pins_raw = {ser_in, ext_in, lvl_in, lvh_in, edg_in, nmi_in};

    irq_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_raw),
        .q_out (pins_s)
    );

    irq_src_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_s     (pins_s[IX_NMI]),
        .edge_s    (pins_s[IX_EDGE]),
        .nmi_clr   (nmi_clr),
        .edge_clr  (edge_clr),
        .nmi_live  (nmi_live),
        .edge_pend (edge_pend)
    );

    // eligibility of each source at this cycle
    always_comb begin
        cand          = '0;
        cand[IX_NMI]  = nmi_live;
        cand[IX_EDGE] = st_q.ien & ~st_q.msk[2] & edge_pend;
        cand[IX_LVH]  = st_q.ien & ~st_q.msk[1] & pins_s[IX_LVH];
        cand[IX_LVL]  = st_q.ien & ~st_q.msk[0] & pins_s[IX_LVL];
        cand[IX_EXT]  = st_q.ien & pins_s[IX_EXT];
    end

    irq_pick u_pick (
        .cand   (cand),
        .sel    (st_q.sel),
        .grant  (grant),
        .vec    (irq_vec),
        .nonvec (irq_nonvec)
    );

    assign ack_ok   = ack & st_q.req;
    assign nmi_clr  = ack_ok & st_q.sel[IX_NMI];
    assign edge_clr = (ack_ok & st_q.sel[IX_EDGE])
                    | (mask_wr & mask_wdata[CW_EDGE_CL]);

    always_comb begin
        st_d = st_q;

        if (ien_set) begin
            st_d.ien = 1'b1;
        end
        if (ien_clr || ack_ok) begin
            st_d.ien = 1'b0;
        end

        if (mask_wr && mask_wdata[CW_MSK_EN]) begin
            st_d.msk = mask_wdata[MSK_W-1:0];
        end
        if (mask_wr && mask_wdata[CW_SER_EN]) begin
            st_d.ser_out = mask_wdata[CW_SER_VAL];
        end

        if (ack_ok) begin
            st_d.req = 1'b0;
            st_d.sel = '0;
        end else if (!st_q.req && insn_end && (|grant)) begin
            st_d.req = 1'b1;
            st_d.sel = grant;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.msk     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req   = st_q.req;
    assign ser_out   = st_q.ser_out;
    assign stat_word = {pins_s[IX_SER], edge_pend, pins_s[IX_LVH],
                        pins_s[IX_LVL], st_q.ien, st_q.msk};

endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_end,
    input logic        ack,
    input logic        mask_wr,
    input logic [7:0]  mask_wdata,
    input logic        irq_req,
    input logic [15:0] irq_vec,
    input logic        irq_nonvec,
    input logic [7:0]  stat_word,
    input logic        ser_out
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !ack |=> irq_req && $stable(irq_vec) && $stable(irq_nonvec)); // R9

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && ack |=> !irq_req && !stat_word[3]); // R6

    AST_NO_STROBE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && !insn_end |=> !irq_req); // R9

    AST_NONVEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nonvec |-> irq_req && irq_vec == 16'h0000); // R2

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_nonvec |-> (irq_vec == 16'h0024 || irq_vec == 16'h003C ||
                                    irq_vec == 16'h0034 || irq_vec == 16'h002C)); // R2

    AST_DISABLED_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && insn_end && !stat_word[3] |=> !irq_req || irq_vec == 16'h0024); // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr && mask_wdata[3]) |=> $stable(stat_word[2:0])); // R7

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr && mask_wdata[6]) |=> $stable(ser_out)); // R8

endmodule

bind irq_front irq_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_end   (insn_end),
    .ack        (ack),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_nonvec (irq_nonvec),
    .stat_word  (stat_word),
    .ser_out    (ser_out)
);

// File: tb/irq_front_tb_top.sv
`timescale 1ns/1ps
module irq_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_in = 1'b0;
    logic        edg_in = 1'b0;
    logic        lvh_in = 1'b0;
    logic        lvl_in = 1'b0;
    logic        ext_in = 1'b0;
    logic        ser_in = 1'b0;
    logic        insn_end = 1'b0;
    logic        ien_set = 1'b0;
    logic        ien_clr = 1'b0;
    logic        ack = 1'b0;
    logic        mask_wr = 1'b0;
    logic [7:0]  mask_wdata = 8'h00;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_nonvec;
    logic [7:0]  stat_word;
    logic        ser_out;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_front dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_in     (nmi_in),
        .edg_in     (edg_in),
        .lvh_in     (lvh_in),
        .lvl_in     (lvl_in),
        .ext_in     (ext_in),
        .ser_in     (ser_in),
        .insn_end   (insn_end),
        .ien_set    (ien_set),
        .ien_clr    (ien_clr),
        .ack        (ack),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .irq_nonvec (irq_nonvec),
        .stat_word  (stat_word),
        .ser_out    (ser_out)
    );

    // pins order {nmi, edge, level-high, level-low, external}
    typedef struct packed {
        logic [4:0]  pins;
        logic        en;
        logic [2:0]  msk;
        logic        req;
        logic        nv;
        logic [15:0] vec;
    } row_t;

    localparam int NROW = 11;
    localparam row_t TAB [NROW] = '{
        '{5'b10000, 1'b0, 3'b111, 1'b1, 1'b0, 16'h0024},
        '{5'b01111, 1'b1, 3'b000, 1'b1, 1'b0, 16'h003C},
        '{5'b00111, 1'b1, 3'b000, 1'b1, 1'b0, 16'h0034},
        '{5'b00011, 1'b1, 3'b000, 1'b1, 1'b0, 16'h002C},
        '{5'b00001, 1'b1, 3'b000, 1'b1, 1'b1, 16'h0000},
        '{5'b01111, 1'b0, 3'b000, 1'b0, 1'b0, 16'h0000},
        '{5'b01110, 1'b1, 3'b100, 1'b1, 1'b0, 16'h0034},
        '{5'b01111, 1'b1, 3'b111, 1'b1, 1'b1, 16'h0000},
        '{5'b11111, 1'b1, 3'b000, 1'b1, 1'b0, 16'h0024},
        '{5'b00110, 1'b1, 3'b010, 1'b1, 1'b0, 16'h002C},
        '{5'b00000, 1'b1, 3'b000, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        {nmi_in, edg_in, lvh_in, lvl_in, ext_in, ser_in} = '0;
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic wr_ctl(input logic [7:0] w);
        mask_wr = 1'b1;
        mask_wdata = w;
        @(negedge clk);
        mask_wr = 1'b0;
        mask_wdata = 8'h00;
    endtask

    task automatic pulse_set();
        ien_set = 1'b1; @(negedge clk); ien_set = 1'b0;
    endtask

    task automatic pulse_clr();
        ien_clr = 1'b1; @(negedge clk); ien_clr = 1'b0;
    endtask

    task automatic strobe();
        insn_end = 1'b1; @(negedge clk); insn_end = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 reset status", {24'h0, stat_word}, 32'h07);
        chk("R9 reset req", {31'h0, irq_req}, 32'h0);
        chk("R8 reset ser_out", {31'h0, ser_out}, 32'h0);

        // table walk: R1 R2 R5 R6 R7
        for (int r = 0; r < NROW; r++) begin
            do_reset();
            if (TAB[r].msk != 3'b111) wr_ctl({5'b00001, TAB[r].msk});
            if (TAB[r].en) pulse_set();
            {nmi_in, edg_in, lvh_in, lvl_in, ext_in} = TAB[r].pins;
            wait_n(5);
            strobe();
            chk($sformatf("R1 row %0d req", r), {31'h0, irq_req}, {31'h0, TAB[r].req});
            chk($sformatf("R2 row %0d vec", r), {16'h0, irq_vec}, {16'h0, TAB[r].vec});
            chk($sformatf("R2 row %0d nonvec", r), {31'h0, irq_nonvec}, {31'h0, TAB[r].nv});
            if (TAB[r].req) begin
                do_ack();
                chk($sformatf("R6 row %0d ack drops req", r), {31'h0, irq_req}, 32'h0);
                chk($sformatf("R6 row %0d ack clears enable", r), {31'h0, stat_word[3]}, 32'h0);
            end
            {nmi_in, edg_in, lvh_in, lvl_in, ext_in} = '0;
        end

        // R3 nmi pulse that falls before the boundary is not taken
        do_reset();
        nmi_in = 1'b1; wait_n(4); nmi_in = 1'b0; wait_n(4);
        strobe();
        chk("R3 nmi level gone", {31'h0, irq_req}, 32'h0);
        // R3 held nmi taken once, no refire while still high
        nmi_in = 1'b1; wait_n(5);
        strobe();
        chk("R3 nmi taken", {16'h0, irq_vec}, 32'h0024);
        do_ack();
        strobe();
        chk("R3 nmi no refire while high", {31'h0, irq_req}, 32'h0);
        nmi_in = 1'b0; wait_n(4); nmi_in = 1'b1; wait_n(5);
        strobe();
        chk("R3 nmi refire after low", {31'h0, irq_req}, 32'h1);
        do_ack();
        nmi_in = 1'b0;

        // R4 edge latch persists, clear bit acts without bit 3
        do_reset();
        edg_in = 1'b1; wait_n(4); edg_in = 1'b0; wait_n(4);
        chk("R4 edge pending after fall", {31'h0, stat_word[6]}, 32'h1);
        wr_ctl(8'h10);
        chk("R4 clear bit drops pending", {31'h0, stat_word[6]}, 32'h0);
        chk("R7 masks unchanged without bit3", {29'h0, stat_word[2:0]}, 32'h7);
        edg_in = 1'b1; wait_n(4); edg_in = 1'b0; wait_n(4);
        wr_ctl(8'h08);
        pulse_set();
        strobe();
        chk("R4 latched edge served", {16'h0, irq_vec}, 32'h003C);
        do_ack();
        chk("R4 ack clears edge latch", {31'h0, stat_word[6]}, 32'h0);

        // R9 no sample without strobe, hold while outstanding
        do_reset();
        wr_ctl(8'h08);
        pulse_set();
        lvl_in = 1'b1; wait_n(10);
        chk("R9 no strobe no req", {31'h0, irq_req}, 32'h0);
        strobe();
        chk("R5 level-low taken", {16'h0, irq_vec}, 32'h002C);
        lvh_in = 1'b1; wait_n(5);
        strobe();
        chk("R9 vector held until ack", {16'h0, irq_vec}, 32'h002C);
        do_ack();
        {lvh_in, lvl_in} = 2'b00;

        // R9 stray ack ignored; R6 enable pulses
        do_reset();
        pulse_set();
        chk("R6 set enable", {31'h0, stat_word[3]}, 32'h1);
        do_ack();
        chk("R9 stray ack ignored", {31'h0, stat_word[3]}, 32'h1);
        ien_set = 1'b1; ien_clr = 1'b1; @(negedge clk); ien_set = 1'b0; ien_clr = 1'b0;
        chk("R6 clear wins over set", {31'h0, stat_word[3]}, 32'h0);
        pulse_set();
        pulse_clr();
        chk("R6 clear enable", {31'h0, stat_word[3]}, 32'h0);

        // R8 serial out and ignored bit
        wr_ctl(8'hC0);
        chk("R8 ser_out load 1", {31'h0, ser_out}, 32'h1);
        wr_ctl(8'h80);
        chk("R8 ser_out held without enable", {31'h0, ser_out}, 32'h1);
        wr_ctl(8'h40);
        chk("R8 ser_out load 0", {31'h0, ser_out}, 32'h0);
        wr_ctl(8'h2D);
        chk("R8 bit5 ignored masks", {29'h0, stat_word[2:0]}, 32'h5);
        chk("R8 bit5 ignored ser_out", {31'h0, ser_out}, 32'h0);

        // R10 serial input and level pins in status
        ser_in = 1'b1; lvh_in = 1'b1; wait_n(3);
        chk("R10 status fields", {24'h0, stat_word}, 32'hA5);
        {ser_in, lvh_in} = 2'b00;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule